// File: doc/BRIEF.md
# Invert-and-Select Integer ALU

This block is a purely combinational integer ALU for a simple processor datapath. Its function is chosen by three independent controls instead of a flat opcode. One bit complements operand A, one bit complements operand B, and a 2-bit select picks which of four result paths drives the output. The four paths are bitwise AND, bitwise OR, the adder, and set-less-than.

Complementing B also forces the adder's carry-in to one, so the same adder computes A minus B. The set-less-than path reuses that subtraction. NOR needs no path of its own: it is AND with both operands complemented.

The block has three outputs: the data result, a flag that is high when the result is all zeros (used to decide branches), and a signed-overflow flag. The overflow flag can only be set while the adder path is selected.

Top module: `inv_sel_alu`

## Requirements
- R1: With both invert bits low and select 2'b00, the result is the bitwise AND of A and B.
- R2: With both invert bits low and select 2'b01, the result is the bitwise OR of A and B.
- R3: With both invert bits low and select 2'b10, the result is A plus B modulo 2^32.
- R4: With the A-invert bit low, the B-invert bit high and select 2'b10, the result is A minus B modulo 2^32. The B-invert bit supplies a carry-in of one.
- R5: With both invert bits high and select 2'b00, the result is the bitwise NOR of A and B.
- R6: Select 2'b11 with only the B-invert bit high drives bit 0 to 1 exactly when A is less than B as signed two's-complement numbers, and drives bits 31..1 to zero. The answer stays correct when the internal subtraction overflows.
- R7: The zero flag is high exactly when all 32 result bits are zero, whatever the select.
- R8: The overflow flag is high only under select 2'b10, and only when the two adder operands (after inversion) have equal sign bits while the sum's sign bit differs from them. Under selects 2'b00, 2'b01 and 2'b11 it is low.
- R9: Each invert bit acts on its own operand alone. For example, A-invert alone with select 2'b00 gives (not A) AND B, and with select 2'b10 gives (not A) plus B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| a_inv_i | input | 1 | Complement operand A before the result paths |
| b_inv_i | input | 1 | Complement operand B and set the adder carry-in |
| sel_i | input | 2 | Result path: 00 AND, 01 OR, 10 sum, 11 set-less-than |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of the sum path |

## Verification
The bench targets set-less-than at the signed extremes, where the subtraction overflows. A design that compared using the raw sign bit would report the most negative value as not less than the most positive one.

It also covers subtraction of the most negative value and from it, and addition that wraps without overflow. These catch a carry-in that is not tied to the B-invert bit and an overflow rule that reads the wrong operand signs.

Further checks confirm that logic and compare paths never raise overflow, and that equal operands under subtraction always raise the zero flag at every bit position. A design that left upper bits set on the compare path would fail the walking-bit comparisons.

// File: rtl/inv_sel_alu_pkg.sv
package inv_sel_alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/inv_sel_operand.sv
module inv_sel_operand #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opd_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] opd_o
);
  assign opd_o = opd_i ^ {WIDTH{inv_i}};
endmodule

// File: rtl/inv_sel_adder.sv
module inv_sel_adder #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  if (RIPPLE) begin : g_ripple
    logic [WIDTH-1:0] carry;
    assign carry[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum_o[i] = x_i[i] ^ y_i[i] ^ carry[i];
      if (i < WIDTH - 1) begin : g_c
        assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
      end
    end
  end else begin : g_behav
    assign sum_o = x_i + y_i + {{(WIDTH-1){1'b0}}, cin_i};
  end
endmodule

// File: rtl/inv_sel_flags.sv
module inv_sel_flags #(
  parameter int WIDTH = 32
) (
  input  logic             x_msb_i,
  input  logic             y_msb_i,
  input  logic             sum_msb_i,
  input  logic [WIDTH-1:0] result_i,
  output logic             ovf_raw_o,
  output logic             less_o,
  output logic             zero_o
);
  // same operand signs, different sum sign
  assign ovf_raw_o = ~(x_msb_i ^ y_msb_i) & (sum_msb_i ^ x_msb_i);
  assign less_o    = sum_msb_i ^ ovf_raw_o;
  assign zero_o    = (result_i == '0);
endmodule

// File: rtl/inv_sel_alu.sv
module inv_sel_alu
  import inv_sel_alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_inv_i,
  input  logic             b_inv_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] a_eff, b_eff, sum;
  logic             ovf_raw, less;
  alu_sel_e         sel;

  assign sel = alu_sel_e'(sel_i);

  inv_sel_operand #(.WIDTH(WIDTH)) u_opa (.opd_i(a_i), .inv_i(a_inv_i), .opd_o(a_eff));
  inv_sel_operand #(.WIDTH(WIDTH)) u_opb (.opd_i(b_i), .inv_i(b_inv_i), .opd_o(b_eff));

  inv_sel_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
    .x_i   (a_eff),
    .y_i   (b_eff),
    .cin_i (b_inv_i),
    .sum_o (sum)
  );

  always_comb begin
    unique case (sel)
      SEL_AND: result_o = a_eff & b_eff;
      SEL_OR:  result_o = a_eff | b_eff;
      SEL_SUM: result_o = sum;
      SEL_SLT: result_o = {{(WIDTH-1){1'b0}}, less};
      default: result_o = '0;
    endcase
  end

  inv_sel_flags #(.WIDTH(WIDTH)) u_flags (
    .x_msb_i   (a_eff[MSB]),
    .y_msb_i   (b_eff[MSB]),
    .sum_msb_i (sum[MSB]),
    .result_i  (result_o),
    .ovf_raw_o (ovf_raw),
    .less_o    (less),
    .zero_o    (zero_o)
  );

  assign ovf_o = (sel == SEL_SUM) & ovf_raw;
endmodule

// File: rtl/inv_sel_alu_chk.sv
module inv_sel_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             a_inv_i,
  input logic             b_inv_i,
  input logic [1:0]       sel_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  always_comb begin
    if (sel_i == 2'b00 && !a_inv_i && !b_inv_i) begin
      // R1
      and_path_chk: assert (result_o == (a_i & b_i)) else $error("and path");
    end
    if (sel_i == 2'b01 && !a_inv_i && !b_inv_i) begin
      // R2
      or_path_chk: assert (result_o == (a_i | b_i)) else $error("or path");
    end
    if (sel_i == 2'b10 && !a_inv_i && !b_inv_i) begin
      // R3
      add_path_chk: assert (result_o == a_i + b_i) else $error("add path");
    end
    if (sel_i == 2'b10 && !a_inv_i && b_inv_i) begin
      // R4
      sub_path_chk: assert (result_o == a_i - b_i) else $error("sub path");
      // R7
      sub_equal_zero_chk: assert (a_i != b_i || zero_o) else $error("equal sub not zero");
    end
    if (sel_i == 2'b00 && a_inv_i && b_inv_i) begin
      // R5
      nor_path_chk: assert (result_o == ~(a_i | b_i)) else $error("nor path");
    end
    if (sel_i == 2'b11) begin
      // R6
      slt_upper_chk: assert ($countones(result_o) <= 1 && !(|result_o[WIDTH-1:1]))
        else $error("slt upper bits");
    end
    if (sel_i != 2'b10) begin
      // R8
      no_overflow_chk: assert (!ovf_o) else $error("overflow outside sum");
    end
  end
endmodule

bind inv_sel_alu inv_sel_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .a_inv_i  (a_inv_i),
  .b_inv_i  (b_inv_i),
  .sel_i    (sel_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/inv_sel_alu_tb.sv
module inv_sel_alu_tb;
  localparam int NV = 26;
  // {req[3:0], a_inv, b_inv, sel[1:0], a, b, result, zero, ovf}
  localparam logic [105:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 2'b00, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b0, 1'b0}, // R1
    {4'd1, 1'b0, 1'b0, 2'b00, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 1'b1, 1'b0}, // R1 R7
    {4'd2, 1'b0, 1'b0, 2'b01, 32'hF000_0001, 32'h0F00_0010, 32'hFF00_0011, 1'b0, 1'b0}, // R2
    {4'd7, 1'b0, 1'b0, 2'b01, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R7
    {4'd3, 1'b0, 1'b0, 2'b10, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0}, // R3
    {4'd3, 1'b0, 1'b0, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0}, // R3
    {4'd8, 1'b0, 1'b0, 2'b10, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1}, // R8
    {4'd8, 1'b0, 1'b0, 2'b10, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1}, // R8
    {4'd4, 1'b0, 1'b1, 2'b10, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 1'b0, 1'b0}, // R4
    {4'd4, 1'b0, 1'b1, 2'b10, 32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9, 1'b0, 1'b0}, // R4
    {4'd7, 1'b0, 1'b1, 2'b10, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0}, // R7
    {4'd8, 1'b0, 1'b1, 2'b10, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R8
    {4'd8, 1'b0, 1'b1, 2'b10, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R8
    {4'd5, 1'b1, 1'b1, 2'b00, 32'hF0F0_0000, 32'h0F0F_0000, 32'h0000_FFFF, 1'b0, 1'b0}, // R5
    {4'd5, 1'b1, 1'b1, 2'b00, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R5
    {4'd6, 1'b0, 1'b1, 2'b11, 32'h0000_0003, 32'h0000_0005, 32'h0000_0001, 1'b0, 1'b0}, // R6
    {4'd6, 1'b0, 1'b1, 2'b11, 32'h0000_0005, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b0}, // R6
    {4'd6, 1'b0, 1'b1, 2'b11, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R6
    {4'd6, 1'b0, 1'b1, 2'b11, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0}, // R6
    {4'd6, 1'b0, 1'b1, 2'b11, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}, // R6
    {4'd6, 1'b0, 1'b1, 2'b11, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R6
    {4'd6, 1'b0, 1'b1, 2'b11, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R6
    {4'd9, 1'b1, 1'b0, 2'b00, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0}, // R9
    {4'd9, 1'b1, 1'b0, 2'b01, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R9
    {4'd9, 1'b1, 1'b0, 2'b10, 32'h0000_0001, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0}, // R9
    {4'd8, 1'b0, 1'b0, 2'b01, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic        a_inv, b_inv, zero, ovf;
  logic [1:0]  sel;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  inv_sel_alu u_dut (
    .a_i(a), .b_i(b), .a_inv_i(a_inv), .b_inv_i(b_inv), .sel_i(sel),
    .result_o(res), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic ai, input logic bi, input logic [1:0] s,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    a_inv = ai; b_inv = bi; sel = s; a = x; b = y;
    #1;
  endtask

  initial begin
    a = '0; b = '0; a_inv = 1'b0; b_inv = 1'b0; sel = 2'b00;
    repeat (2) @(negedge clk);
    #1;
    check("R7 reset zero flag", {31'b0, zero}, 32'd1);
    check("R1 reset result", res, 32'd0);
    check("R8 reset ovf", {31'b0, ovf}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][101], VEC[i][100], VEC[i][99:98], VEC[i][97:66], VEC[i][65:34]);
      check($sformatf("R%0d vec %0d result", VEC[i][105:102], i), res, VEC[i][33:2]);
      check($sformatf("R%0d vec %0d zero", VEC[i][105:102], i), {31'b0, zero}, {31'b0, VEC[i][1]});
      check($sformatf("R%0d vec %0d ovf", VEC[i][105:102], i), {31'b0, ovf}, {31'b0, VEC[i][0]});
    end

    // R7: equal operands under subtraction, walking bit
    for (int i = 0; i < 32; i++) begin
      apply(1'b0, 1'b1, 2'b10, 32'h1 << i, 32'h1 << i);
      check("R7 walking equal sub zero", {31'b0, zero}, 32'd1);
    end
    // R6: walking bit versus zero, only bit 31 is negative
    for (int i = 0; i < 32; i++) begin
      apply(1'b0, 1'b1, 2'b11, 32'h1 << i, 32'h0);
      check("R6 walking slt", res, (i == 31) ? 32'd1 : 32'd0);
      check("R8 slt no ovf", {31'b0, ovf}, 32'd0);
    end
    // R4: subtract most negative from -1
    apply(1'b0, 1'b1, 2'b10, 32'hFFFF_FFFF, 32'h8000_0000);
    check("R4 sub min", res, 32'h7FFF_FFFF);
    check("R8 sub min no ovf", {31'b0, ovf}, 32'd0);
    // R5: NOR of alternating patterns
    apply(1'b1, 1'b1, 2'b00, 32'hAAAA_0000, 32'h0000_5555);
    check("R5 nor mixed", res, 32'h5555_AAAA);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule